// File: doc/BRIEF.md
# Dual-clock burst write staging FIFO

This block queues write data that application logic produces on its own clock, so that a bus-side engine on a second clock can send the data out as one burst. The application side hands over narrow beats with an active-low enable. A fixed number of beats make up one stored entry, and each entry carries an active-low end-of-transfer marker. The write side reports an active-low full flag, an active-low almost-full flag, and a saturating count of beats it had to drop. It also provides a ready output that stays low during reset and while a clear is in progress.

The bus side sees an active-low empty flag and a burst-start gate, `go`. The application can hold the gate closed with an active-low hold input until enough data has been queued. The gate opens when the hold is released. It also opens when the queue fills, even if the hold is still asserted. Once the gate is open, one entry leaves the queue on every bus clock for as long as data is available. Each entry comes out with a valid strobe and its end-of-transfer marker, so the consumer can close the burst. Pointers cross between the clock domains as Gray codes through two-flop synchronisers. A synchronous clear on the application clock empties the queue and closes the gate again, ready for the next transfer.

Top module: `burst_stage_fifo`

## Requirements
- R1: A beat is taken on a rising edge of `wclk` when `wr_en_n` is 0 and `ready` is 1 and the queue is not full. `BEATS` taken beats (default 2) form one entry. The first beat goes into the lowest `BEAT_W` bits of the entry.
- R2: `full_n` is 0 exactly while the queue holds `DEPTH` entries (default 16). A beat offered while `full_n` is 0 is dropped, and the data already stored is left intact.
- R3: `ovf_cnt` rises by one for each beat that is dropped because the queue is full. It saturates at all ones and clears only on `rst`.
- R4: `afull_n` is 0 while 4 or fewer entries are free (parameter `AF_ROOM`), and therefore also whenever `full_n` is 0.
- R5: `empty_n` is produced on `rclk` and is 0 while the bus side sees no stored entry. No entry is popped while it is 0.
- R6: While the gate is closed and `hold_n` is 0, `go` stays 0 unless the queue is full. `go` becomes 1 when `hold_n` is 1 or the queue is full, and then stays 1 until a clear.
- R7: While `go` is 1 and the queue is not empty, one entry is popped per `rclk` cycle. It appears on `rd_data` with `rd_valid` = 1 one cycle later, and entries leave in write order.
- R8: `rd_last_n` of an entry equals the `wr_last_n` value given with the final beat of that entry. The marker given with earlier beats is ignored.
- R9: `hold_err` pulses high for one `rclk` cycle when `hold_n` has been 0 for exactly one cycle and then returns to 1.
- R10: `ready` is 0 while `rst` is 1 and from the cycle after `clr` until the clear has completed in both domains. Beats offered while `ready` is 0 are ignored and not counted as drops.
- R11: After a clear completes, the queue is empty (`empty_n` = 0, `full_n` = 1) and `go` is 0 again while `hold_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Application clock |
| rclk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| clr | input | 1 | One-cycle clear request on `wclk` |
| ready | output | 1 | High when the write side accepts beats |
| wr_en_n | input | 1 | Active-low beat write enable |
| wr_data | input | BEAT_W | Beat data |
| wr_last_n | input | 1 | Active-low end-of-transfer marker, used on the final beat only |
| full_n | output | 1 | Active-low full flag (`wclk`) |
| afull_n | output | 1 | Active-low almost-full flag (`wclk`) |
| ovf_cnt | output | OVF_W | Saturating count of dropped beats |
| hold_n | input | 1 | Active-low burst hold (`rclk`) |
| empty_n | output | 1 | Active-low empty flag (`rclk`) |
| go | output | 1 | Burst-start gate, pops are allowed while high |
| rd_valid | output | 1 | High in the cycle after a pop |
| rd_data | output | BEAT_W*BEATS | Popped entry data |
| rd_last_n | output | 1 | Popped entry end-of-transfer marker |
| hold_err | output | 1 | One-cycle pulse on a hold shorter than two cycles |

## Verification
Two pairs of functions can meet in the same cycle. In the first, a push on the application clock and a pop on the bus clock happen together. The bench provokes this by releasing the hold and then streaming ten entries while the gate is open, with the two clocks at unrelated periods. A queue-based model on the bus clock checks every popped entry, including its marker, against the write order. In the second, the queue fills while the hold is still asserted, and beats keep arriving behind the last free slot. Here the bench checks the drop count, checks that `go` opens with the hold still low, and checks that exactly the sixteen first entries drain unaltered.

// File: rtl/burst_stage_pkg.sv
package burst_stage_pkg;

    // Widest pointer the helpers handle; callers cast to their own width.
    localparam int PTR_MAX = 16;

    typedef logic [PTR_MAX-1:0] ptr_t;

    // Burst gate: closed until released by hold or a full queue.
    typedef enum logic {
        GATE_ARMED = 1'b0,
        GATE_RUN   = 1'b1
    } gate_e;

    function automatic ptr_t to_gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t from_gray(input ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/burst_stage_sync.sv
module burst_stage_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/burst_stage_ram.sv
module burst_stage_ram #(
    parameter  int DEPTH = 16,
    parameter  int W     = 33,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/burst_stage_wr.sv
module burst_stage_wr
    import burst_stage_pkg::*;
#(
    parameter  int DEPTH   = 16,
    parameter  int BEAT_W  = 16,
    parameter  int BEATS   = 2,
    parameter  int AF_ROOM = 4,
    parameter  int OVF_W   = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1,
    localparam int WORD_W  = BEAT_W * BEATS,
    localparam int BI      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en_n,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic              wr_last_n,
    input  logic [PW-1:0]     rgray_sync,
    input  logic              clr_ack_sync,
    output logic              ready,
    output logic              full_n,
    output logic              afull_n,
    output logic [OVF_W-1:0]  ovf_cnt,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [WORD_W:0]   wword,
    output logic [PW-1:0]     wgray,
    output logic              clr_req
);

    logic [PW-1:0]     wbin, rbin, used, free_slots;
    logic [BI-1:0]     beat_idx;
    logic [WORD_W-1:0] partial_q, word_c;
    logic              full, beat_ok, final_beat, clr_start;

    assign rbin       = PW'(from_gray(ptr_t'(rgray_sync)));
    assign used       = wbin - rbin;
    assign free_slots = PW'(DEPTH) - used;
    assign full       = (used == PW'(DEPTH));
    assign full_n     = !full;
    assign afull_n    = !(free_slots <= PW'(AF_ROOM));

    assign ready      = !rst && !clr_req && !clr_ack_sync;
    assign clr_start  = clr && !clr_req && !clr_ack_sync;
    assign beat_ok    = !wr_en_n && ready && !full && !clr;
    assign final_beat = (beat_idx == BI'(BEATS - 1));
    assign we         = beat_ok && final_beat;
    assign waddr      = wbin[AW-1:0];

    always_comb begin
        word_c = partial_q;
        word_c[(BEATS-1)*BEAT_W +: BEAT_W] = wr_data;
    end

    assign wword = {wr_last_n, word_c};

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin      <= '0;
            wgray     <= '0;
            beat_idx  <= '0;
            partial_q <= '0;
            ovf_cnt   <= '0;
            clr_req   <= 1'b0;
        end else if (clr_start) begin
            clr_req  <= 1'b1;
            wbin     <= '0;
            wgray    <= '0;
            beat_idx <= '0;
        end else begin
            if (clr_req && clr_ack_sync) begin
                clr_req <= 1'b0;
            end
            if (beat_ok) begin
                if (final_beat) begin
                    beat_idx <= '0;
                    wbin     <= wbin + 1'b1;
                    wgray    <= PW'(to_gray(ptr_t'(wbin + 1'b1)));
                end else begin
                    partial_q[beat_idx*BEAT_W +: BEAT_W] <= wr_data;
                    beat_idx <= beat_idx + 1'b1;
                end
            end
            if (!wr_en_n && ready && full && (ovf_cnt != {OVF_W{1'b1}})) begin
                ovf_cnt <= ovf_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_stage_rd.sv
module burst_stage_rd
    import burst_stage_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          clr_req_sync,
    input  logic [PW-1:0] wgray_sync,
    input  logic          hold_n,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          empty_n,
    output logic          go,
    output logic          rd_valid,
    output logic          hold_err,
    output logic          clr_ack
);

    logic [PW-1:0] rbin, wbin_r, used;
    logic          empty, rfull;
    logic          hold_d1, hold_d2;
    gate_e         gate;

    assign wbin_r  = PW'(from_gray(ptr_t'(wgray_sync)));
    assign used    = wbin_r - rbin;
    assign empty   = (used == '0);
    assign rfull   = (used == PW'(DEPTH));
    assign empty_n = !empty;
    assign go      = (gate == GATE_RUN);
    assign re      = go && !empty && !clr_req_sync;
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin     <= '0;
            rgray    <= '0;
            gate     <= GATE_ARMED;
            rd_valid <= 1'b0;
            hold_d1  <= 1'b1;
            hold_d2  <= 1'b1;
            hold_err <= 1'b0;
            clr_ack  <= 1'b0;
        end else begin
            clr_ack  <= clr_req_sync;
            hold_d1  <= hold_n;
            hold_d2  <= hold_d1;
            hold_err <= hold_n && !hold_d1 && hold_d2;
            if (clr_req_sync) begin
                rbin     <= '0;
                rgray    <= '0;
                gate     <= GATE_ARMED;
                rd_valid <= 1'b0;
            end else begin
                rd_valid <= re;
                if (re) begin
                    rbin  <= rbin + 1'b1;
                    rgray <= PW'(to_gray(ptr_t'(rbin + 1'b1)));
                end
                if (gate == GATE_ARMED && (hold_n || rfull)) begin
                    gate <= GATE_RUN;
                end
            end
        end
    end

endmodule

// File: rtl/burst_stage_fifo.sv
module burst_stage_fifo #(
    parameter  int DEPTH   = 16,
    parameter  int BEAT_W  = 16,
    parameter  int BEATS   = 2,
    parameter  int AF_ROOM = 4,
    parameter  int OVF_W   = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = AW + 1,
    localparam int WORD_W  = BEAT_W * BEATS
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              clr,
    output logic              ready,
    input  logic              wr_en_n,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic              wr_last_n,
    output logic              full_n,
    output logic              afull_n,
    output logic [OVF_W-1:0]  ovf_cnt,
    input  logic              hold_n,
    output logic              empty_n,
    output logic              go,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last_n,
    output logic              hold_err
);

    logic [PW-1:0]   wgray_w, wgray_r, rgray_r, rgray_w;
    logic            clr_req_w, clr_req_r, clr_ack_r, clr_ack_w;
    logic            we, re;
    logic [AW-1:0]   waddr, raddr;
    logic [WORD_W:0] wword, rword;

    burst_stage_wr #(
        .DEPTH(DEPTH), .BEAT_W(BEAT_W), .BEATS(BEATS),
        .AF_ROOM(AF_ROOM), .OVF_W(OVF_W)
    ) u_wr (
        .wclk(wclk), .rst(rst), .clr(clr),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_last_n(wr_last_n),
        .rgray_sync(rgray_w), .clr_ack_sync(clr_ack_w),
        .ready(ready), .full_n(full_n), .afull_n(afull_n), .ovf_cnt(ovf_cnt),
        .we(we), .waddr(waddr), .wword(wword), .wgray(wgray_w),
        .clr_req(clr_req_w)
    );

    burst_stage_rd #(.DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst(rst), .clr_req_sync(clr_req_r),
        .wgray_sync(wgray_r), .hold_n(hold_n),
        .re(re), .raddr(raddr), .rgray(rgray_r),
        .empty_n(empty_n), .go(go), .rd_valid(rd_valid),
        .hold_err(hold_err), .clr_ack(clr_ack_r)
    );

    burst_stage_ram #(.DEPTH(DEPTH), .W(WORD_W + 1)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wword),
        .rclk(rclk), .re(re), .raddr(raddr), .rdata(rword)
    );

    burst_stage_sync #(.W(PW)) u_sync_w2r (
        .clk(rclk), .rst(rst), .d(wgray_w), .q(wgray_r)
    );

    burst_stage_sync #(.W(PW)) u_sync_r2w (
        .clk(wclk), .rst(rst), .d(rgray_r), .q(rgray_w)
    );

    burst_stage_sync #(.W(1)) u_sync_clr (
        .clk(rclk), .rst(rst), .d(clr_req_w), .q(clr_req_r)
    );

    burst_stage_sync #(.W(1)) u_sync_ack (
        .clk(wclk), .rst(rst), .d(clr_ack_r), .q(clr_ack_w)
    );

    assign rd_data   = rword[WORD_W-1:0];
    assign rd_last_n = rword[WORD_W];

endmodule

// File: rtl/burst_stage_fifo_chk.sv
module burst_stage_fifo_chk #(
    parameter int PW    = 5,
    parameter int OVF_W = 8
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst,
    input logic             clr,
    input logic             ready,
    input logic             wr_en_n,
    input logic             full_n,
    input logic             afull_n,
    input logic [OVF_W-1:0] ovf_cnt,
    input logic [PW-1:0]    wgray,
    input logic             hold_n,
    input logic             empty_n,
    input logic             go,
    input logic             rd_valid,
    input logic             hold_err
);

    // R2
    full_keeps_ptr_chk: assert property (@(posedge wclk) disable iff (rst)
        (!full_n && !clr) |=> $stable(wgray));

    // R3
    ovf_step_chk: assert property (@(posedge wclk) disable iff (rst)
        (!wr_en_n && ready && !full_n && !clr && (ovf_cnt != {OVF_W{1'b1}}))
        |=> (ovf_cnt == $past(ovf_cnt) + 1'b1));

    // R4
    afull_on_full_chk: assert property (@(posedge wclk) disable iff (rst)
        !full_n |-> !afull_n);

    // R5
    no_pop_empty_chk: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |=> !rd_valid);

    // R6
    gate_held_chk: assert property (@(posedge rclk) disable iff (rst)
        (!go && !hold_n && !empty_n) |=> !go);

    // R7
    valid_after_go_chk: assert property (@(posedge rclk) disable iff (rst)
        rd_valid |-> $past(go));

    // R9
    hold_err_shape_chk: assert property (@(posedge rclk) disable iff (rst)
        hold_err |-> ($past(hold_n) && !$past(hold_n, 2)));

    // R10
    ready_in_reset_chk: assert property (@(posedge wclk)
        rst |-> !ready);

    // R10
    ready_after_clr_chk: assert property (@(posedge wclk) disable iff (rst)
        clr |=> !ready);

endmodule

bind burst_stage_fifo burst_stage_fifo_chk #(.PW(PW), .OVF_W(OVF_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .clr(clr), .ready(ready),
    .wr_en_n(wr_en_n), .full_n(full_n), .afull_n(afull_n), .ovf_cnt(ovf_cnt),
    .wgray(wgray_w), .hold_n(hold_n), .empty_n(empty_n), .go(go),
    .rd_valid(rd_valid), .hold_err(hold_err)
);

// File: tb/burst_stage_fifo_test.sv
module burst_stage_fifo_test;

    localparam int DEPTH  = 16;
    localparam int BEAT_W = 16;
    localparam int BEATS  = 2;
    localparam int OVF_W  = 8;
    localparam int WORD_W = BEAT_W * BEATS;

    logic              wclk = 1'b0, rclk = 1'b0;
    logic              rst = 1'b1, clr = 1'b0;
    logic              ready, full_n, afull_n, empty_n, go, rd_valid, rd_last_n, hold_err;
    logic              wr_en_n = 1'b1, wr_last_n = 1'b1, hold_n = 1'b0;
    logic [BEAT_W-1:0] wr_data = '0;
    logic [OVF_W-1:0]  ovf_cnt;
    logic [WORD_W-1:0] rd_data;

    int total = 0, failed = 0, err_seen = 0, popped = 0;
    bit done = 1'b0;

    logic [WORD_W:0]   expq[$];
    logic [WORD_W-1:0] part;
    int                bbeat = 0;

    always #5 wclk = ~wclk;
    always #6 rclk = ~rclk;

    burst_stage_fifo #(
        .DEPTH(DEPTH), .BEAT_W(BEAT_W), .BEATS(BEATS), .AF_ROOM(4), .OVF_W(OVF_W)
    ) uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .clr(clr), .ready(ready),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_last_n(wr_last_n),
        .full_n(full_n), .afull_n(afull_n), .ovf_cnt(ovf_cnt),
        .hold_n(hold_n), .empty_n(empty_n), .go(go), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last_n(rd_last_n), .hold_err(hold_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Read-side reference: every popped entry must match the write order (R7, R8).
    always @(negedge rclk) begin
        if (!rst) begin
            if (hold_err) err_seen++;
            if (rd_valid) begin
                popped++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R7 unexpected pop", {31'd0, rd_last_n, rd_data}, 64'd0);
                end else begin
                    logic [WORD_W:0] e;
                    e = expq.pop_front();
                    chk({rd_last_n, rd_data} == e, "R7/R8 popped entry",
                        {31'd0, rd_last_n, rd_data}, {31'd0, e});
                end
            end
        end
    end

    task automatic write_beat(input logic [BEAT_W-1:0] d, input logic last_n);
        @(negedge wclk);
        wr_en_n   = 1'b0;
        wr_data   = d;
        wr_last_n = last_n;
        #1;
        if (ready && full_n) begin
            if (bbeat == BEATS - 1) begin
                logic [WORD_W-1:0] w;
                w = part;
                w[(BEATS-1)*BEAT_W +: BEAT_W] = d;
                expq.push_back({last_n, w});
                bbeat = 0;
            end else begin
                part[bbeat*BEAT_W +: BEAT_W] = d;
                bbeat++;
            end
        end
    endtask

    // Marker on non-final beats is driven low when mark_early is set (R8).
    task automatic write_word(input logic [WORD_W-1:0] w, input bit mark_early, input logic last_n);
        for (int b = 0; b < BEATS; b++) begin
            write_beat(w[b*BEAT_W +: BEAT_W], (b == BEATS - 1) ? last_n : !mark_early);
        end
    endtask

    task automatic wait_w(input int n);
        @(negedge wclk);
        wr_en_n   = 1'b1;
        wr_last_n = 1'b1;
        repeat (n) @(negedge wclk);
    endtask

    task automatic do_clear();
        @(negedge wclk);
        wr_en_n = 1'b1;
        clr     = 1'b1;
        @(negedge wclk);
        clr = 1'b0;
        chk(ready == 1'b0, "R10 ready low after clr", {63'd0, ready}, 64'd0);
        bbeat = 0;
        expq.delete();
        // Beat offered while not ready must vanish (R10).
        write_beat(16'hDEAD, 1'b0);
        wait_w(0);
        for (int i = 0; i < 100 && !ready; i++) @(negedge wclk);
        chk(ready == 1'b1, "R10 ready back after clear", {63'd0, ready}, 64'd1);
        repeat (6) @(negedge rclk);
        chk(go == 1'b0, "R11 gate re-armed", {63'd0, go}, 64'd0);
        chk(empty_n == 1'b0, "R11 empty after clear", {63'd0, empty_n}, 64'd0);
        chk(full_n == 1'b1, "R11 not full after clear", {63'd0, full_n}, 64'd1);
    endtask

    initial begin
        repeat (20000) @(posedge wclk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        part = '0;
        repeat (3) @(negedge wclk);
        chk(ready == 1'b0, "R10 ready low in reset", {63'd0, ready}, 64'd0);
        chk(go == 1'b0, "R6 go low in reset", {63'd0, go}, 64'd0);
        chk(rd_valid == 1'b0, "R7 no valid in reset", {63'd0, rd_valid}, 64'd0);
        repeat (3) @(negedge wclk);
        rst = 1'b0;
        repeat (6) @(negedge wclk);
        chk(ready == 1'b1, "R10 ready after reset", {63'd0, ready}, 64'd1);
        chk(full_n && afull_n, "R2/R4 flags idle", {62'd0, full_n, afull_n}, 64'd3);
        chk(empty_n == 1'b0, "R5 empty after reset", {63'd0, empty_n}, 64'd0);
        chk(ovf_cnt == '0, "R3 ovf zero", 64'(ovf_cnt), 64'd0);

        // Hold keeps the gate closed while entries queue up (R1, R6, R8).
        write_word(32'h2222_1111, 1'b1, 1'b1);
        write_word(32'h4444_3333, 1'b0, 1'b1);
        write_word(32'h6666_5555, 1'b0, 1'b0);
        wait_w(2);
        repeat (10) @(negedge rclk);
        chk(go == 1'b0, "R6 go held", {63'd0, go}, 64'd0);
        chk(popped == 0, "R6 nothing popped during hold", 64'(popped), 64'd0);
        chk(empty_n == 1'b1, "R5 not empty", {63'd0, empty_n}, 64'd1);
        chk(afull_n && full_n, "R4 three entries not almost full", {62'd0, full_n, afull_n}, 64'd3);
        @(negedge rclk);
        hold_n = 1'b1;
        repeat (20) @(negedge rclk);
        chk(go == 1'b1, "R6 go after release", {63'd0, go}, 64'd1);
        chk(expq.size() == 0, "R7 all drained", 64'(expq.size()), 64'd0);
        chk(popped == 3, "R1 three entries formed", 64'(popped), 64'd3);
        chk(empty_n == 1'b0, "R5 empty after drain", {63'd0, empty_n}, 64'd0);

        @(negedge rclk);
        hold_n = 1'b0;
        do_clear();

        // Fill with hold low: almost-full, full, drops, forced start (R2, R3, R4, R6).
        for (int i = 0; i < 11; i++) write_word(32'hA000_0000 + 32'(i), 1'b0, 1'b1);
        wait_w(2);
        chk(afull_n == 1'b1, "R4 five free", {63'd0, afull_n}, 64'd1);
        write_word(32'hA000_000B, 1'b0, 1'b1);
        wait_w(2);
        chk(afull_n == 1'b0, "R4 four free", {63'd0, afull_n}, 64'd0);
        chk(full_n == 1'b1, "R2 twelve not full", {63'd0, full_n}, 64'd1);
        for (int i = 12; i < DEPTH; i++) write_word(32'hA000_0000 + 32'(i), 1'b0, (i == DEPTH - 1) ? 1'b0 : 1'b1);
        write_word(32'hBAD0_BAD1, 1'b0, 1'b0);
        wait_w(0);
        chk(ovf_cnt == 8'd2, "R3 two beats dropped", 64'(ovf_cnt), 64'd2);
        repeat (40) @(negedge rclk);
        chk(go == 1'b1, "R6 forced start on full", {63'd0, go}, 64'd1);
        chk(hold_n == 1'b0, "R6 hold still asserted", {63'd0, hold_n}, 64'd0);
        chk(expq.size() == 0, "R2 stored data drained intact", 64'(expq.size()), 64'd0);
        chk(full_n == 1'b1, "R2 full released after drain", {63'd0, full_n}, 64'd1);

        // Hold pulse shorter than two cycles is flagged, two cycles is not (R9).
        @(negedge rclk);
        hold_n = 1'b1;
        repeat (3) @(negedge rclk);
        err_seen = 0;
        hold_n = 1'b0;
        @(negedge rclk);
        hold_n = 1'b1;
        repeat (5) @(negedge rclk);
        chk(err_seen == 1, "R9 short hold flagged", 64'(err_seen), 64'd1);
        err_seen = 0;
        hold_n = 1'b0;
        repeat (2) @(negedge rclk);
        hold_n = 1'b1;
        repeat (5) @(negedge rclk);
        chk(err_seen == 0, "R9 two-cycle hold accepted", 64'(err_seen), 64'd0);
        hold_n = 1'b0;
        repeat (3) @(negedge rclk);

        do_clear();

        // Push and pop overlap with the gate open (R7).
        @(negedge rclk);
        hold_n = 1'b1;
        for (int i = 0; i < 10; i++) write_word({16'(i * 7), 16'hC000 + 16'(i)}, i[0], i[1] ? 1'b0 : 1'b1);
        wait_w(2);
        repeat (40) @(negedge rclk);
        chk(expq.size() == 0, "R7 concurrent stream drained", 64'(expq.size()), 64'd0);
        chk(empty_n == 1'b0, "R5 empty at end", {63'd0, empty_n}, 64'd0);
        chk(ovf_cnt == 8'd2, "R3 count unchanged", 64'(ovf_cnt), 64'd2);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule